// File: doc/BRIEF.md
# Polarity-Selectable Phase-Frequency Detector

This block is the digital half of a frequency synthesiser loop. It divides its own clock by a programmable ratio R to make a reference pulse train, and it takes a feedback pulse train from the loop's divided oscillator. It compares the two trains with a four-state phase-frequency detector and issues up and down pump requests. An external charge pump turns these requests into sourcing and sinking current. A single direction input sets the sense of the loop. It inverts the pump polarity, and it also exchanges which of the two monitor pins shows the reference train and which shows the feedback train.

All control inputs (R, direction, detector enable, monitor enable, gain code) are registered before use, and they reset to all ones. The block therefore runs with its widest ratio, positive polarity and every output enabled when nothing is programmed. The 2-bit gain code is only registered and passed out to an external current scaler.

The detector states are ST_IDLE (no request), ST_REF_AHEAD (a reference edge is waiting for a feedback edge), ST_FB_AHEAD (a feedback edge is waiting for a reference edge) and ST_CANCEL (both sides have arrived, and both requests are shown for one cycle). The transitions are as follows. ST_IDLE goes to ST_REF_AHEAD on a reference event alone, to ST_FB_AHEAD on a feedback event alone, and to ST_CANCEL on both events at once. ST_REF_AHEAD goes to ST_CANCEL on a feedback event. ST_FB_AHEAD goes to ST_CANCEL on a reference event. ST_CANCEL always returns to ST_IDLE. Any state goes to ST_IDLE while the registered detector enable is low.

Top module: `pfd_polarity_top`

## Requirements
- R1: During and after synchronous reset the pump outputs and monitor outputs are 0, `gain_out` is all ones, and the registered direction, detector enable, monitor enable and ratio are all ones.
- R2: The reference event is high for exactly one clock once every R clocks. It is first high in the R-th cycle after the divider count starts from 0. An R of 0 or 1 gives an event in every cycle.
- R3: A feedback event is a rising edge of `fb_in` (`fb_in` high now, low in the previous cycle). An event alone on one side moves ST_IDLE to the matching ahead state on the next clock, and the request holds until the other side's event arrives.
- R4: With direction 1, ST_FB_AHEAD drives `pump_dn`=1 and `pump_up`=0 (sink when feedback leads), and ST_REF_AHEAD drives `pump_up`=1 and `pump_dn`=0.
- R5: With direction 0, the mapping of R4 is reversed: ST_FB_AHEAD drives `pump_up` and ST_REF_AHEAD drives `pump_dn`.
- R6: When both sides have arrived (in sequence or in the same cycle), both pumps are 1 for exactly one cycle (ST_CANCEL), then both are 0.
- R7: While the registered detector enable is 0, both pumps are 0 and the detector is returned to ST_IDLE, so a pending request is discarded.
- R8: With direction 1, `mon_a` carries the feedback event and `mon_b` the reference event. With direction 0, the two pins swap.
- R9: While the registered monitor enable is 0, `mon_a` and `mon_b` are 0.
- R10: `gain_out` follows `gain_in` one clock later and has no effect on the pump outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| r_div_in | input | RW | Reference division ratio R |
| fb_in | input | 1 | Feedback pulse train, synchronous to clk |
| dir_in | input | 1 | Direction select (pump polarity and monitor assignment) |
| det_en_in | input | 1 | Detector enable |
| mon_en_in | input | 1 | Monitor output enable |
| gain_in | input | GW | Pump current gain code |
| pump_up | output | 1 | Source request to the charge pump |
| pump_dn | output | 1 | Sink request to the charge pump |
| mon_a | output | 1 | Monitor pin A (feedback when direction is 1) |
| mon_b | output | 1 | Monitor pin B (reference when direction is 1) |
| gain_out | output | GW | Registered gain code |

## Verification
The bench builds the block with RW=4 and GW=2. The reset-default ratio of 15 therefore produces a reference event within a few tens of cycles, and the all-ones default can be observed on a monitor pin. The scenario tests program R=6, which leaves room to place a feedback edge before, at the same time as, or after the reference edge. R=1 reaches the every-cycle corner of the divider.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REF_AHEAD = 2'd1,
        ST_FB_AHEAD  = 2'd2,
        ST_CANCEL    = 2'd3
    } pfd_state_e;

endpackage

// File: rtl/pfd_input_stage.sv
module pfd_input_stage #(
    parameter int RW = 8,
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] r_div_in,
    input  logic          fb_in,
    input  logic          dir_in,
    input  logic          det_en_in,
    input  logic          mon_en_in,
    input  logic [GW-1:0] gain_in,
    output logic [RW-1:0] r_q,
    output logic          dir_q,
    output logic          det_en_q,
    output logic          mon_en_q,
    output logic [GW-1:0] gain_q,
    output logic          fb_evt
);
    logic fb_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q      <= '1;
            dir_q    <= 1'b1;
            det_en_q <= 1'b1;
            mon_en_q <= 1'b1;
            gain_q   <= '1;
            fb_prev  <= 1'b0;
        end else begin
            r_q      <= r_div_in;
            dir_q    <= dir_in;
            det_en_q <= det_en_in;
            mon_en_q <= mon_en_in;
            gain_q   <= gain_in;
            fb_prev  <= fb_in;
        end
    end

    assign fb_evt = fb_in & ~fb_prev;

    // A feedback level held high produces only one event
    assert_fb_single_R3: assert property (@(posedge clk) disable iff (rst)
        (fb_evt && fb_in) |=> !fb_evt);

endmodule

// File: rtl/pfd_ref_divider.sv
module pfd_ref_divider #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] r_q,
    output logic          ref_evt
);
    localparam logic [RW-1:0] ONE = RW'(1);

    logic [RW-1:0] cnt;
    logic          short_ratio;
    logic          at_end;

    assign short_ratio = (r_q <= ONE);
    assign at_end      = short_ratio || (cnt >= r_q - ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end

    assign ref_evt = short_ratio || (cnt == r_q - ONE);

    // With a ratio above one and held still, events are one cycle wide
    assert_ref_width_R2: assert property (@(posedge clk) disable iff (rst)
        (ref_evt && (r_q > ONE) && $stable(r_q)) |=> !ref_evt);

endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       ref_evt,
    input  logic       fb_evt,
    output logic       raw_up,
    output logic       raw_dn,
    output pfd_state_e state_o
);
    pfd_state_e state_q;
    pfd_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ref_evt && fb_evt) state_d = ST_CANCEL;
                    else if (ref_evt)      state_d = ST_REF_AHEAD;
                    else if (fb_evt)       state_d = ST_FB_AHEAD;
                end
                ST_REF_AHEAD: if (fb_evt)  state_d = ST_CANCEL;
                ST_FB_AHEAD:  if (ref_evt) state_d = ST_CANCEL;
                ST_CANCEL:                 state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        raw_up = 1'b0;
        raw_dn = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_REF_AHEAD: raw_up = 1'b1;
            ST_FB_AHEAD:  raw_dn = 1'b1;
            ST_CANCEL: begin
                raw_up = 1'b1;
                raw_dn = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

    assert_cancel_once_R6: assert property (@(posedge clk) disable iff (rst)
        (raw_up && raw_dn) |=> !(raw_up && raw_dn));

    assert_disable_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state_q == ST_IDLE));

    assert_no_direct_swap_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REF_AHEAD) |=> (state_q != ST_FB_AHEAD));

endmodule

// File: rtl/pfd_output_map.sv
module pfd_output_map (
    input  logic dir_q,
    input  logic det_en_q,
    input  logic mon_en_q,
    input  logic raw_up,
    input  logic raw_dn,
    input  logic ref_evt,
    input  logic fb_evt,
    output logic pump_up,
    output logic pump_dn,
    output logic mon_a,
    output logic mon_b
);
    always_comb begin
        pump_up = 1'b0;
        pump_dn = 1'b0;
        if (det_en_q) begin
            pump_up = dir_q ? raw_up : raw_dn;
            pump_dn = dir_q ? raw_dn : raw_up;
        end
    end

    always_comb begin
        mon_a = 1'b0;
        mon_b = 1'b0;
        if (mon_en_q) begin
            mon_a = dir_q ? fb_evt  : ref_evt;
            mon_b = dir_q ? ref_evt : fb_evt;
        end
    end

    // Pin A shows the feedback train with direction 1 and the reference train otherwise
    always_comb begin
        assert_mon_assign_R8: assert (!(mon_en_q && dir_q && fb_evt && !ref_evt) || (mon_a && !mon_b));
    end

endmodule

// File: rtl/pfd_polarity_top.sv
module pfd_polarity_top
    import pfd_pkg::*;
#(
    parameter int RW = 8,
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] r_div_in,
    input  logic          fb_in,
    input  logic          dir_in,
    input  logic          det_en_in,
    input  logic          mon_en_in,
    input  logic [GW-1:0] gain_in,
    output logic          pump_up,
    output logic          pump_dn,
    output logic          mon_a,
    output logic          mon_b,
    output logic [GW-1:0] gain_out
);
    logic [RW-1:0] r_q;
    logic          dir_q;
    logic          det_en_q;
    logic          mon_en_q;
    logic [GW-1:0] gain_q;
    logic          fb_evt;
    logic          ref_evt;
    logic          raw_up;
    logic          raw_dn;
    pfd_state_e    state;

    pfd_input_stage #(.RW(RW), .GW(GW)) u_inputs (
        .clk(clk), .rst(rst), .r_div_in(r_div_in), .fb_in(fb_in),
        .dir_in(dir_in), .det_en_in(det_en_in), .mon_en_in(mon_en_in),
        .gain_in(gain_in), .r_q(r_q), .dir_q(dir_q), .det_en_q(det_en_q),
        .mon_en_q(mon_en_q), .gain_q(gain_q), .fb_evt(fb_evt)
    );

    pfd_ref_divider #(.RW(RW)) u_refdiv (
        .clk(clk), .rst(rst), .r_q(r_q), .ref_evt(ref_evt)
    );

    pfd_state_core u_core (
        .clk(clk), .rst(rst), .enable(det_en_q), .ref_evt(ref_evt),
        .fb_evt(fb_evt), .raw_up(raw_up), .raw_dn(raw_dn), .state_o(state)
    );

    pfd_output_map u_map (
        .dir_q(dir_q), .det_en_q(det_en_q), .mon_en_q(mon_en_q),
        .raw_up(raw_up), .raw_dn(raw_dn), .ref_evt(ref_evt), .fb_evt(fb_evt),
        .pump_up(pump_up), .pump_dn(pump_dn), .mon_a(mon_a), .mon_b(mon_b)
    );

    assign gain_out = gain_q;

    // Feedback leading with positive direction must request sink only
    assert_fb_lead_sink_R4: assert property (@(posedge clk) disable iff (rst)
        (dir_q && det_en_q && state == ST_FB_AHEAD) |-> (pump_dn && !pump_up));

    assert_fb_lead_source_R5: assert property (@(posedge clk) disable iff (rst)
        (!dir_q && det_en_q && state == ST_FB_AHEAD) |-> (pump_up && !pump_dn));

endmodule

// File: tb/pfd_polarity_top_tb.sv
module pfd_polarity_top_tb_top;
    localparam int RW = 4;
    localparam int GW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] r_div_in = '1;
    logic          fb_in = 1'b0;
    logic          dir_in = 1'b1;
    logic          det_en_in = 1'b1;
    logic          mon_en_in = 1'b1;
    logic [GW-1:0] gain_in = '1;
    logic          pump_up, pump_dn, mon_a, mon_b;
    logic [GW-1:0] gain_out;

    int checks = 0;
    int failures = 0;
    int cur = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pfd_polarity_top #(.RW(RW), .GW(GW)) dut_i (
        .clk(clk), .rst(rst), .r_div_in(r_div_in), .fb_in(fb_in),
        .dir_in(dir_in), .det_en_in(det_en_in), .mon_en_in(mon_en_in),
        .gain_in(gain_in), .pump_up(pump_up), .pump_dn(pump_dn),
        .mon_a(mon_a), .mon_b(mon_b), .gain_out(gain_out)
    );

    // vector fields: {dir, det_en, mon_en, fb_first, gain[1:0]}
    localparam logic [5:0] VEC [8] = '{
        6'b111100, 6'b111001, 6'b011110, 6'b011011,
        6'b101100, 6'b010001, 6'b110111, 6'b001010
    };

    task automatic chk(string req, string what, logic [GW-1:0] act, logic [GW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reset with the given controls; interval I0 starts at release
    task automatic do_reset(logic [RW-1:0] r, logic d, logic de, logic me, logic [GW-1:0] g);
        @(posedge clk); #1;
        rst = 1'b1; fb_in = 1'b0;
        r_div_in = r; dir_in = d; det_en_in = de; mon_en_in = me; gain_in = g;
        @(posedge clk); #1;
        rst = 1'b0;
        cur = 0;
    endtask

    task automatic goto(int k);
        while (cur < k) begin
            @(posedge clk); #1;
            cur++;
        end
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        smp();
        chk("R1", "pump_up in reset", pump_up, 0);
        chk("R1", "pump_dn in reset", pump_dn, 0);
        chk("R1", "mon_a in reset", mon_a, 0);
        chk("R1", "mon_b in reset", mon_b, 0);
        chk("R1", "gain_out in reset", gain_out, 2'b11);

        // Vector table: R=6, ref event during I5, feedback at I2 or I8
        for (int v = 0; v < 8; v++) begin
            logic d, de, me, ff;
            logic [GW-1:0] g;
            {d, de, me, ff, g} = VEC[v];
            do_reset(4'd6, d, de, me, g);
            if (ff) begin
                goto(2); fb_in = 1'b1; smp();
                chk("R8", "fb pin during fb event", d ? mon_a : mon_b, me);
                chk("R9", "ref pin during fb event", d ? mon_b : mon_a, 0);
                goto(3); fb_in = 1'b0;
                goto(4); smp();
                // R3/R4/R5: feedback ahead
                chk(d ? "R4" : "R5", "pump_dn fb ahead", pump_dn, de & d);
                chk(d ? "R4" : "R5", "pump_up fb ahead", pump_up, de & ~d);
                chk("R10", "gain_out", gain_out, g);
                goto(5); smp();
                chk("R8", "ref pin during ref event", d ? mon_b : mon_a, me);
                goto(6); smp();
                chk("R6", "both pumps cancel", {pump_up, pump_dn}, {de, de});
                goto(7); smp();
                chk("R6", "pumps idle after cancel", {pump_up, pump_dn}, 2'b00);
            end else begin
                goto(5); smp();
                chk("R8", "ref pin during ref event", d ? mon_b : mon_a, me);
                chk("R9", "fb pin idle", d ? mon_a : mon_b, 0);
                goto(7); smp();
                chk(d ? "R4" : "R5", "pump_up ref ahead", pump_up, de & d);
                chk(d ? "R4" : "R5", "pump_dn ref ahead", pump_dn, de & ~d);
                chk("R10", "gain no effect on pumps", gain_out, g);
                goto(8); fb_in = 1'b1;
                goto(9); fb_in = 1'b0; smp();
                chk("R6", "both pumps cancel", {pump_up, pump_dn}, {de, de});
                goto(10); smp();
                chk("R6", "pumps idle after cancel", {pump_up, pump_dn}, 2'b00);
            end
        end

        // R1/R2: all-ones ratio gives period 15
        do_reset('1, 1'b1, 1'b1, 1'b1, '1);
        goto(13); smp(); chk("R2", "no ref event before R", mon_b, 0);
        goto(14); smp(); chk("R1", "ref event at default R", mon_b, 1);
        goto(15); smp(); chk("R2", "ref event one cycle", mon_b, 0);
        goto(29); smp(); chk("R2", "second ref event", mon_b, 1);

        // R2: R=1 gives an event every cycle
        do_reset(4'd1, 1'b1, 1'b1, 1'b1, '1);
        goto(3); smp(); chk("R2", "R=1 event", mon_b, 1);
        goto(4); smp(); chk("R2", "R=1 next event", mon_b, 1);

        // R6: simultaneous edges
        do_reset(4'd6, 1'b1, 1'b1, 1'b1, '1);
        goto(5); fb_in = 1'b1;
        goto(6); fb_in = 1'b0; smp();
        chk("R6", "simultaneous cancel", {pump_up, pump_dn}, 2'b11);
        goto(7); smp();
        chk("R6", "simultaneous idle", {pump_up, pump_dn}, 2'b00);

        // R7: disable discards a pending request
        do_reset(4'd6, 1'b1, 1'b1, 1'b1, '1);
        goto(2); fb_in = 1'b1;
        goto(3); fb_in = 1'b0; det_en_in = 1'b0;
        goto(4); det_en_in = 1'b1; smp();
        chk("R7", "pumps off while disabled", {pump_up, pump_dn}, 2'b00);
        goto(6); smp();
        chk("R7", "request discarded", {pump_up, pump_dn}, 2'b10);

        // R10: gain latency
        do_reset(4'd6, 1'b1, 1'b1, 1'b1, 2'b11);
        goto(3); gain_in = 2'b10; smp();
        chk("R10", "gain before edge", gain_out, 2'b11);
        goto(4); smp();
        chk("R10", "gain after edge", gain_out, 2'b10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule